// File: doc/BRIEF.md
# 16K Bank Mapping Unit for an 8-bit CPU

This block sits between an 8-bit CPU with a 64K address space and a memory array of up to 4MB. It divides the CPU space into four 16K windows. Each window has its own 8-bit bank register, and that register provides the upper bits of the physical address. The 14 low address bits pass through unchanged. Software loads the bank registers through a group of four I/O ports. The registers cannot be read back.

After a hardware reset, the unit is in a boot state. In this state every window shows the top bank, which lies in ROM, so the CPU can start from the ROM at any address. The first write to any of the four ports ends the boot state for good. The same write also loads the register it addresses.

Device selects are decoded from the translated bank bits, not from the CPU address. One ROM device and a parameterised number of RAM devices each receive an active-high select. At most one select is raised at a time, and only during a memory cycle that is not a refresh.

Top module: `cpu_bank_mapper`

## Requirements
- R1: CPU address bits 15:14 pick one of four 16K windows. Bits 13:0 appear unchanged on physical address bits 13:0.
- R2: Outside the boot state, physical bits 21:14 equal the 8-bit bank register of the window picked by CPU bits 15:14.
- R3: The port group is the four I/O addresses whose bits 7:2 match PORT_BASE bits 7:2 (default 0x38 to 0x3B). CPU bits 1:0 pick the window register to load. I/O writes to any other address change nothing.
- R4: On a port write, data bits 3:0 load register bits 3:0 (physical bits 17:14) and data bits 7:4 load register bits 7:4 (physical bits 21:18).
- R5: While the boot state is active, physical bits 21:14 read 0xFF in every window, so the ROM select is raised for any CPU address.
- R6: Any port write ends the boot state on the clock edge that captures the write. The boot state does not return until rst_ni is asserted again.
- R7: Physical bit 17 set selects the ROM. Bit 17 clear selects RAM device number physical[21:18]. A RAM number at or above RAM_DEVS selects no device.
- R8: At most one device select is high at any time.
- R9: Device selects are low unless mreq_ni is low and rfsh_ni is high. Address translation is unaffected by these two inputs.
- R10: I/O reads of the port group and memory writes that carry a port address leave every bank register and the boot state unchanged.
- R11: Reset clears all four bank registers to zero. A window that has not been loaded since reset maps to bank 0 once the boot state ends.
- R12: One I/O write strobe loads a register once, with the data present in its first cycle. Holding the strobe for more cycles has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus (write data) |
| iorq_ni | input | 1 | I/O request, active low |
| mreq_ni | input | 1 | Memory request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rfsh_ni | input | 1 | Refresh cycle marker, active low |
| phys_addr_o | output | 22 | Translated physical address |
| rom_sel_o | output | 1 | ROM device select, active high |
| ram_sel_o | output | RAM_DEVS | RAM device selects, active high |

## Verification
Translation and device selects are purely combinational from the bus and the stored registers. A probe is therefore due in the same cycle as its inputs, and the bench samples it 1 ns after the next rising edge, while the probe inputs are still held. A port write takes effect on the first rising edge at which its strobe is seen. Its effect on translation and on the boot state is therefore due one cycle after it is driven, and the bench issues the next probe only after that edge. Each probe's expected value is pushed to a queue by the driver. The monitor pops and compares it at the sampling point, so every comparison falls exactly one edge after its stimulus.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CPU_AW    = 16;
  localparam int AREA_W    = 2;
  localparam int N_AREAS   = 1 << AREA_W;
  localparam int OFFS_W    = CPU_AW - AREA_W;
  localparam int BANK_W    = 8;
  localparam int NIB_W     = 4;
  localparam int N_NIBS    = BANK_W / NIB_W;
  localparam int PHYS_W    = BANK_W + OFFS_W;
  localparam int IO_AW     = 8;
  localparam int DEV_IDX_W = BANK_W - NIB_W;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [AREA_W-1:0] area_t;
endpackage

// File: rtl/cbm_port_decode.sv
module cbm_port_decode
  import cbm_pkg::*;
#(
  parameter logic [IO_AW-1:0] PORT_BASE = 8'h38
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             iorq_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  output logic             wr_stb_o,
  output area_t            wr_area_o
);
  localparam int MATCH_W = IO_AW - AREA_W;

  logic hit;
  logic raw_stb;
  logic raw_q;

  assign hit       = io_addr_i[IO_AW-1:AREA_W] == PORT_BASE[IO_AW-1:AREA_W];
  assign raw_stb   = !iorq_ni && !wr_ni && rd_ni && hit;
  assign wr_area_o = io_addr_i[AREA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= raw_stb;
  end

  // one load per strobe: leading cycle only
  assign wr_stb_o = raw_stb && !raw_q;

  AST_SINGLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R12

  logic unused_w;
  assign unused_w = ^MATCH_W;
endmodule

// File: rtl/cbm_bank_file.sv
module cbm_bank_file
  import cbm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  area_t             wr_area_i,
  input  logic [BANK_W-1:0] wr_data_i,
  input  area_t             rd_area_i,
  output bank_t             bank_o,
  output logic              boot_o
);
  logic [N_AREAS-1:0][BANK_W-1:0] entry_q;
  logic                           boot_q;

  // each window register is built from nibble lanes fed by matching data lanes
  for (genvar a = 0; a < N_AREAS; a++) begin : g_area
    for (genvar n = 0; n < N_NIBS; n++) begin : g_nib
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          entry_q[a][n*NIB_W +: NIB_W] <= '0;
        else if (wr_stb_i && wr_area_i == area_t'(a))
          entry_q[a][n*NIB_W +: NIB_W] <= wr_data_i[n*NIB_W +: NIB_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       boot_q <= 1'b1;
    else if (wr_stb_i) boot_q <= 1'b0;
  end

  assign bank_o = boot_q ? '1 : entry_q[rd_area_i];
  assign boot_o = boot_q;

  AST_BOOT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_q |=> !boot_q); // R6
  AST_BOOT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !boot_q); // R6
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(entry_q)); // R10
endmodule

// File: rtl/cbm_chip_decode.sv
module cbm_chip_decode
  import cbm_pkg::*;
#(
  parameter int RAM_DEVS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DEV_IDX_W-1:0] dev_idx_i,
  input  logic                 rom_bit_i,
  input  logic                 mreq_ni,
  input  logic                 rfsh_ni,
  output logic                 rom_sel_o,
  output logic [RAM_DEVS-1:0]  ram_sel_o
);
  logic cycle_ok;
  assign cycle_ok  = !mreq_ni && rfsh_ni;
  assign rom_sel_o = cycle_ok && rom_bit_i;

  for (genvar d = 0; d < RAM_DEVS; d++) begin : g_ram
    assign ram_sel_o[d] = cycle_ok && !rom_bit_i && (dev_idx_i == DEV_IDX_W'(d));
  end

  AST_ONE_DEVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o})); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_ni || !rfsh_ni) |-> (!rom_sel_o && ram_sel_o == '0)); // R9
endmodule

// File: rtl/cpu_bank_mapper.sv
module cpu_bank_mapper
  import cbm_pkg::*;
#(
  parameter int                RAM_DEVS  = 4,
  parameter logic [IO_AW-1:0]  PORT_BASE = 8'h38
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CPU_AW-1:0]   cpu_addr_i,
  input  logic [BANK_W-1:0]   cpu_data_i,
  input  logic                iorq_ni,
  input  logic                mreq_ni,
  input  logic                rd_ni,
  input  logic                wr_ni,
  input  logic                rfsh_ni,
  output logic [PHYS_W-1:0]   phys_addr_o,
  output logic                rom_sel_o,
  output logic [RAM_DEVS-1:0] ram_sel_o
);
  logic  wr_stb;
  area_t wr_area;
  bank_t bank;
  logic  boot;

  cbm_port_decode #(.PORT_BASE(PORT_BASE)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .io_addr_i (cpu_addr_i[IO_AW-1:0]),
    .iorq_ni   (iorq_ni),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .wr_stb_o  (wr_stb),
    .wr_area_o (wr_area)
  );

  cbm_bank_file u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .wr_area_i (wr_area),
    .wr_data_i (cpu_data_i),
    .rd_area_i (cpu_addr_i[CPU_AW-1:OFFS_W]),
    .bank_o    (bank),
    .boot_o    (boot)
  );

  assign phys_addr_o = {bank, cpu_addr_i[OFFS_W-1:0]};

  cbm_chip_decode #(.RAM_DEVS(RAM_DEVS)) u_cs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_idx_i (phys_addr_o[PHYS_W-1:PHYS_W-DEV_IDX_W]),
    .rom_bit_i (phys_addr_o[OFFS_W+NIB_W-1]),
    .mreq_ni   (mreq_ni),
    .rfsh_ni   (rfsh_ni),
    .rom_sel_o (rom_sel_o),
    .ram_sel_o (ram_sel_o)
  );

  AST_BOOT_TOP_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot |-> phys_addr_o[PHYS_W-1:OFFS_W] == '1); // R5

  logic unused_bits;
  assign unused_bits = ^phys_addr_o[OFFS_W+NIB_W-2:0];
endmodule

// File: tb/sim_cpu_bank_mapper.sv
module sim_cpu_bank_mapper;
  localparam int RAM_DEVS = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_ni;
  logic [15:0]         addr;
  logic [7:0]          data;
  logic                iorq_n, mreq_n, rd_n, wr_n, rfsh_n;
  logic [21:0]         phys;
  logic                rom_sel;
  logic [RAM_DEVS-1:0] ram_sel;

  cpu_bank_mapper #(.RAM_DEVS(RAM_DEVS), .PORT_BASE(8'h38)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(addr), .cpu_data_i(data),
    .iorq_ni(iorq_n), .mreq_ni(mreq_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .rfsh_ni(rfsh_n), .phys_addr_o(phys), .rom_sel_o(rom_sel), .ram_sel_o(ram_sel)
  );

  typedef struct packed {
    logic [21:0]         phys;
    logic                rom;
    logic [RAM_DEVS-1:0] ram;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;

  logic [7:0] m_bank [4];
  logic       m_boot;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_bank[i] = 8'h00;  // R11
    m_boot = 1'b1;
  endtask

  function automatic exp_t predict(input logic [15:0] a, input logic mq, input logic rf);
    exp_t e;
    logic [7:0] b;
    b = m_boot ? 8'hFF : m_bank[a[15:14]];          // R2 R5
    e.phys = {b, a[13:0]};                          // R1
    e.rom  = !mq && rf && b[3];                     // R7 R9
    for (int d = 0; d < RAM_DEVS; d++)
      e.ram[d] = !mq && rf && !b[3] && (b[7:4] == 4'(d));
    return e;
  endfunction

  task automatic probe(input logic [15:0] a, input logic mq, input logic rf, input string tag);
    @(negedge clk);
    addr = a; mreq_n = mq; rfsh_n = rf; iorq_n = 1'b1; rd_n = mq; wr_n = 1'b1;
    exp_q.push_back(predict(a, mq, rf));
    tag_q.push_back(tag);
  endtask

  // one bus cycle; the model loads only a port-group I/O write (R3 R10)
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                           input logic io, input logic mq, input logic rdn, input logic wrn);
    @(negedge clk);
    addr = a; data = d; iorq_n = io; mreq_n = mq; rd_n = rdn; wr_n = wrn; rfsh_n = 1'b1;
    if (!io && !wrn && rdn && a[7:2] == 6'h0E) begin
      m_bank[a[1:0]] = d;                           // R4
      m_boot = 1'b0;                                // R6
    end
    @(negedge clk);
    iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic port_write(input logic [7:0] p, input logic [7:0] d);
    bus_cycle({8'h00, p}, d, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  // monitor: compare one queued item per edge, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (phys !== e.phys || rom_sel !== e.rom || ram_sel !== e.ram) begin
          failures++;
          $display("FAIL %s: actual phys=%h rom=%b ram=%b expected phys=%h rom=%b ram=%b",
                   t, phys, rom_sel, ram_sel, e.phys, e.rom, e.ram);
        end
        checks++;
        if ($countones({rom_sel, ram_sel}) > 1) begin
          failures++;
          $display("FAIL R8: actual selects=%b expected at most one high", {rom_sel, ram_sel});
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; addr = '0; data = '0;
    iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rfsh_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // boot state
    probe(16'h0000, 1'b0, 1'b1, "R5 boot area0");
    probe(16'h4123, 1'b0, 1'b1, "R5 boot area1");
    probe(16'hBFFF, 1'b0, 1'b1, "R5 boot area2");
    probe(16'hC000, 1'b0, 1'b1, "R1 boot area3 offset");
    probe(16'h1234, 1'b1, 1'b1, "R9 no mreq");
    probe(16'h1234, 1'b0, 1'b0, "R9 refresh");

    // ignored cycles
    bus_cycle(16'h0039, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1);  // port read
    probe(16'h8000, 1'b0, 1'b1, "R10 port read ignored");
    bus_cycle(16'h003C, 8'h55, 1'b0, 1'b1, 1'b1, 1'b0);  // off-group write
    probe(16'h8000, 1'b0, 1'b1, "R3 off-group write ignored");
    bus_cycle(16'h0038, 8'h55, 1'b1, 1'b0, 1'b1, 1'b0);  // memory write
    probe(16'h0010, 1'b0, 1'b1, "R10 memory write ignored");

    // first port write ends boot
    port_write(8'h3A, 8'h06);
    probe(16'h8ABC, 1'b0, 1'b1, "R6 boot exit area2");
    probe(16'h0000, 1'b0, 1'b1, "R11 area0 zero");
    probe(16'hFFFF, 1'b0, 1'b1, "R11 area3 zero");

    port_write(8'h3B, 8'h0B);
    probe(16'hC001, 1'b0, 1'b1, "R7 rom bank");
    port_write(8'h38, 8'h25);
    probe(16'h2222, 1'b0, 1'b1, "R4 nibble lanes ram2");
    port_write(8'h39, 8'hA3);
    probe(16'h7FFF, 1'b0, 1'b1, "R7 out-of-range ram");
    port_write(8'h3B, 8'hF8);
    probe(16'hD00D, 1'b0, 1'b1, "R2 high bank rom");
    probe(16'h4000, 1'b0, 1'b1, "R6 boot stays off");

    // strobe held three cycles, data changes after the first
    @(negedge clk);
    addr = 16'h0038; data = 8'h41; iorq_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; mreq_n = 1'b1;
    m_bank[0] = 8'h41;
    @(negedge clk); data = 8'h99;
    @(negedge clk); data = 8'h77;
    @(negedge clk); iorq_n = 1'b1; wr_n = 1'b1;
    probe(16'h0100, 1'b0, 1'b1, "R12 held strobe single load");

    // second reset restores boot and clears registers
    @(negedge clk); rst_ni = 1'b0; model_reset();
    @(negedge clk); rst_ni = 1'b1;
    probe(16'h0100, 1'b0, 1'b1, "R5 boot after reset");
    port_write(8'h3B, 8'h02);
    probe(16'h0100, 1'b0, 1'b1, "R11 cleared after reset");
    probe(16'hC100, 1'b0, 1'b1, "R2 area3 after reset");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule